// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns two active-low external interrupt pins into registered request lines for a CPU core. One pin is maskable. It is gated by an enable input and by the CPU's interrupt mask bit, and it can be set to trigger on a low level or on a falling edge. The other pin is the non-maskable source. It stays blocked from reset until software first clears its mask bit. After that the block ignores any later attempt to set the mask again.

Both pins are brought into the clock domain through a synchronizer chain before any decision is made. No glitch filter is applied, so a single synchronized low sample or a single falling edge is enough to act on.

In falling-edge mode a latched pending flag holds the maskable request. The flag is released by a clear strobe, or it is discarded when the enable input drops. While a stop-mode indication is present, the block also raises a wakeup output whenever either source is active.

Top module: `ext_irq_cond`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `irq_req`, `nmi_req` and `wake` are 0. The non-maskable source is locked, and pins that idle high produce no edge.
- R2: Level mode (`irq_edge_mode`=0): with `irq_en`=1 and `cpu_i_mask`=0, `irq_req` goes to 1 three clocks after `irq_pin_n` goes low. It returns to 0 three clocks after the pin goes high, with no latching.
- R3: When `irq_en`=0, `irq_req` is 0 on the next clock. A pending edge is discarded, so re-enabling while the pin stays high raises no request.
- R4: When `cpu_i_mask`=1, `irq_req` is 0 on the next clock. In edge mode a latched pending flag is kept and shows again one clock after the mask is cleared.
- R5: Edge mode (`irq_edge_mode`=1): a synchronized high-to-low transition while `irq_en`=1 latches a pending request. That request holds after the pin returns high. A one-cycle `flag_clr` removes it on the next clock. If a new edge and `flag_clr` arrive on the same clock, the edge wins.
- R6: Edge mode: once the flag is cleared, a pin that stays low does not raise the request again.
- R7: `nmi_req` stays 0 until `cpu_x_mask` has been sampled at 0 at least once since reset. Driving `cpu_x_mask` back to 1 afterwards has no effect.
- R8: Once unlocked, `nmi_req` follows the synchronized low level of `nmi_pin_n`. It rises one clock after the unlock if the pin is already low, and falls three clocks after the pin goes high.
- R9: `wake` is 1 one clock after `stop_mode`=1 coincides with an active source, and 0 one clock after `stop_mode`=0. An active source is an enabled maskable pin whose level or pending state is active, regardless of `cpu_i_mask`, or an unlocked non-maskable pin that is low.
- R10: No glitch filtering: a low pulse on `irq_pin_n` lasting one clock period latches a pending request in edge mode.
- R11: Switching `irq_edge_mode` to 0 drops a pending flag. Switching back to 1 while the pin is high raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| irq_en | input | 1 | Enable for the maskable pin |
| irq_edge_mode | input | 1 | Trigger select: 0 low level, 1 falling edge |
| cpu_i_mask | input | 1 | CPU maskable-interrupt mask, 1 blocks |
| cpu_x_mask | input | 1 | CPU non-maskable mask, only its first clear counts |
| stop_mode | input | 1 | Device is in stop mode |
| flag_clr | input | 1 | One-cycle strobe clearing the pending edge flag |
| irq_req | output | 1 | Registered maskable request |
| nmi_req | output | 1 | Registered non-maskable request |
| wake | output | 1 | Registered wakeup indication |

## Verification
A pin change reaches its request output after three clocks: two synchronizer stages, then the output register. Every control input (`irq_en`, `cpu_i_mask`, `cpu_x_mask`, `flag_clr`, `stop_mode`, `irq_edge_mode`) takes effect after exactly one clock. The bench drives inputs just after a falling clock edge and samples exactly that many falling edges later. Where the count matters it also checks one cycle earlier, so that an early response is caught. The same-clock collision of an edge with `flag_clr` is timed so that the synchronized fall and the strobe meet at the same rising edge.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_maskable_path.sv
module irq_maskable_path
  import irq_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_s,
  input  logic       en,
  input  trig_mode_e mode,
  input  logic       imask,
  input  logic       clr,
  output logic       req_q,
  output logic       active
);
  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic fall;

  assign fall = prev_q & ~pin_s;

  always_comb begin
    pend_d = 1'b0;
    if (mode == TRIG_FALL && en) begin
      if (fall)          pend_d = 1'b1;
      else if (clr)      pend_d = 1'b0;
      else               pend_d = pend_q;
    end
  end

  assign active = en & ((mode == TRIG_FALL) ? pend_d : ~pin_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_d;
      req_q  <= active & ~imask;
    end
  end
endmodule

// File: rtl/irq_nmi_path.sv
module irq_nmi_path (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic xmask,
  output logic req_q,
  output logic active
);
  logic unlocked_q;
  logic unlocked_d;

  assign unlocked_d = unlocked_q | ~xmask;
  assign active     = unlocked_d & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked_q <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      req_q      <= active;
    end
  end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import irq_cond_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_pin_n,
  input  logic nmi_pin_n,
  input  logic irq_en,
  input  logic irq_edge_mode,
  input  logic cpu_i_mask,
  input  logic cpu_x_mask,
  input  logic stop_mode,
  input  logic flag_clr,
  output logic irq_req,
  output logic nmi_req,
  output logic wake
);
  localparam int unsigned NPINS = 2;

  logic [NPINS-1:0] pins_raw;
  logic [NPINS-1:0] pins_s;
  logic             mk_active;
  logic             nmi_active;
  logic             wake_q;
  trig_mode_e       mode;

  assign pins_raw = {nmi_pin_n, irq_pin_n};
  assign mode     = trig_mode_e'(irq_edge_mode);

  irq_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NPINS{1'b1}})
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pins_raw),
    .q  (pins_s)
  );

  irq_maskable_path u_mk (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pins_s[0]),
    .en    (irq_en),
    .mode  (mode),
    .imask (cpu_i_mask),
    .clr   (flag_clr),
    .req_q (irq_req),
    .active(mk_active)
  );

  irq_nmi_path u_nmi (
    .clk   (clk),
    .rst   (rst),
    .pin_s (pins_s[1]),
    .xmask (cpu_x_mask),
    .req_q (nmi_req),
    .active(nmi_active)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= stop_mode & (mk_active | nmi_active);
  end

  assign wake = wake_q;
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk (
  input logic clk,
  input logic rst,
  input logic irq_en,
  input logic irq_edge_mode,
  input logic cpu_i_mask,
  input logic cpu_x_mask,
  input logic stop_mode,
  input logic flag_clr,
  input logic irq_req,
  input logic nmi_req,
  input logic wake
);
  logic x_seen_q;

  always_ff @(posedge clk) begin
    if (rst) x_seen_q <= 1'b0;
    else if (!cpu_x_mask) x_seen_q <= 1'b1;
  end

  p_en_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_req);

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_i_mask |=> !irq_req);

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_edge_mode && irq_en && !cpu_i_mask && !flag_clr) |=> irq_req);

  p_nmi_lock_r7: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> x_seen_q);

  p_wake_stop_r9: assert property (@(posedge clk) disable iff (rst)
    !stop_mode |=> !wake);
endmodule

bind ext_irq_cond irq_cond_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_en       (irq_en),
  .irq_edge_mode(irq_edge_mode),
  .cpu_i_mask   (cpu_i_mask),
  .cpu_x_mask   (cpu_x_mask),
  .stop_mode    (stop_mode),
  .flag_clr     (flag_clr),
  .irq_req      (irq_req),
  .nmi_req      (nmi_req),
  .wake         (wake)
);

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_pin_n = 1'b1, nmi_pin_n = 1'b1;
  logic irq_en = 1'b0, irq_edge_mode = 1'b0, cpu_i_mask = 1'b1;
  logic cpu_x_mask = 1'b1, stop_mode = 1'b0, flag_clr = 1'b0;
  logic irq_req, nmi_req, wake;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ext_irq_cond dut_i (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .nmi_pin_n(nmi_pin_n),
    .irq_en(irq_en), .irq_edge_mode(irq_edge_mode), .cpu_i_mask(cpu_i_mask),
    .cpu_x_mask(cpu_x_mask), .stop_mode(stop_mode), .flag_clr(flag_clr),
    .irq_req(irq_req), .nmi_req(nmi_req), .wake(wake)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    irq_pin_n = 1'b1; nmi_pin_n = 1'b1; irq_en = 1'b0; irq_edge_mode = 1'b0;
    cpu_i_mask = 1'b1; cpu_x_mask = 1'b1; stop_mode = 1'b0; flag_clr = 1'b0;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  // Edge mode, enabled, unmasked, with one pending edge latched and pin high again.
  task automatic make_pending();
    do_reset();
    irq_edge_mode = 1'b1; irq_en = 1'b1; cpu_i_mask = 1'b0;
    irq_pin_n = 1'b0; step(3);
    irq_pin_n = 1'b1; step(3);
  endtask

  initial begin
    step(4);
    // R1: reset state, nmi pin low while locked
    nmi_pin_n = 1'b0;
    step(1);
    chk("R1 irq_req in reset", irq_req, 1'b0);
    chk("R1 nmi_req in reset", nmi_req, 1'b0);
    chk("R1 wake in reset", wake, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 irq_req after reset", irq_req, 1'b0);
    chk("R7 nmi locked after reset", nmi_req, 1'b0);

    // Sweep: mode x enable x mask with pin pulled low then released
    for (int c = 0; c < 8; c++) begin
      logic m, e, im, exp_low, exp_high;
      m = c[2]; e = c[1]; im = c[0];
      do_reset();
      irq_edge_mode = m; irq_en = e; cpu_i_mask = im;
      step(1);
      irq_pin_n = 1'b0; step(4);
      exp_low  = e & ~im;
      exp_high = m & e & ~im;
      chk(m ? "R5 sweep low" : "R2 sweep low", irq_req, exp_low);
      irq_pin_n = 1'b1; step(4);
      chk(m ? "R5 sweep released" : "R2 sweep released", irq_req, exp_high);
      if (im) begin
        cpu_i_mask = 1'b0; step(1);
        chk("R4 mask release sweep", irq_req, m & e);
      end
    end

    // R2 latency in level mode
    do_reset();
    irq_en = 1'b1; cpu_i_mask = 1'b0; step(1);
    irq_pin_n = 1'b0; step(2);
    chk("R2 not yet at 2 clocks", irq_req, 1'b0);
    step(1);
    chk("R2 raised at 3 clocks", irq_req, 1'b1);
    irq_pin_n = 1'b1; step(2);
    chk("R2 still high at 2 clocks", irq_req, 1'b1);
    step(1);
    chk("R2 follows pin high", irq_req, 0);

    // R5 clear strobe, then collision of edge and clear
    make_pending();
    chk("R5 held after pin high", irq_req, 1'b1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R5 cleared by strobe", irq_req, 1'b0);
    irq_pin_n = 1'b0; step(2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R5 edge wins over clear", irq_req, 1'b1);
    // R6: clear with pin still low
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R6 cleared while low", irq_req, 1'b0);
    step(4);
    chk("R6 steady low no retrigger", irq_req, 1'b0);

    // R3 withdraw and discard
    make_pending();
    irq_en = 1'b0; step(1);
    chk("R3 withdrawn on disable", irq_req, 1'b0);
    irq_en = 1'b1; step(2);
    chk("R3 pending discarded", irq_req, 1'b0);

    // R4 pending retained under mask
    make_pending();
    cpu_i_mask = 1'b1; step(1);
    chk("R4 masked", irq_req, 1'b0);
    step(2);
    cpu_i_mask = 1'b0; step(1);
    chk("R4 pending reappears", irq_req, 1'b1);

    // R11 mode switch drops pending
    make_pending();
    irq_edge_mode = 1'b0; step(1);
    chk("R11 level mode pin high", irq_req, 1'b0);
    irq_edge_mode = 1'b1; step(1);
    chk("R11 pending dropped", irq_req, 1'b0);

    // R10 one-clock pulse latches in edge mode
    do_reset();
    irq_edge_mode = 1'b1; irq_en = 1'b1; cpu_i_mask = 1'b0; step(1);
    irq_pin_n = 1'b0; step(1);
    irq_pin_n = 1'b1; step(2);
    chk("R10 one-clock pulse latched", irq_req, 1'b1);

    // R7 / R8 non-maskable source
    do_reset();
    nmi_pin_n = 1'b0; step(4);
    chk("R7 locked with pin low", nmi_req, 1'b0);
    cpu_x_mask = 1'b0; step(1);
    cpu_x_mask = 1'b1;
    chk("R8 rises one clock after unlock", nmi_req, 1'b1);
    step(3);
    chk("R7 remask ignored", nmi_req, 1'b1);
    nmi_pin_n = 1'b1; step(2);
    chk("R8 still high at 2 clocks", nmi_req, 1'b1);
    step(1);
    chk("R8 follows pin high", nmi_req, 1'b0);
    nmi_pin_n = 1'b0; step(3);
    chk("R8 follows pin low again", nmi_req, 1'b1);

    // R9 wake: non-maskable source in stop mode
    stop_mode = 1'b1; step(1);
    chk("R9 wake from nmi", wake, 1'b1);
    stop_mode = 1'b0; step(1);
    chk("R9 wake low out of stop", wake, 1'b0);

    // R9 wake: maskable level source under CPU mask
    do_reset();
    irq_en = 1'b1; cpu_i_mask = 1'b1; irq_pin_n = 1'b0; step(4);
    chk("R9 no wake outside stop", wake, 1'b0);
    stop_mode = 1'b1; step(1);
    chk("R9 wake ignores cpu mask", wake, 1'b1);
    chk("R9 request still masked", irq_req, 1'b0);
    irq_en = 1'b0; step(1);
    chk("R9 disabled pin no wake", wake, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule